// File: doc/BRIEF.md
# Two-Stage Instruction Front End with Decode-Stage Branch Resolution

This block is the front of a simple in-order pipeline. Its fetch stage presents a byte address to a synchronous instruction memory every cycle. It keeps stepping that address by one word and assumes that every branch falls through. The word returned by the memory becomes the decode-stage instruction one cycle later. Decode inspects it for a compare-equal branch and reports the two source register indices. It compares the two operand values that the register file returns for those indices. When the values match, it redirects fetch to the branch target.

The word fetched while the branch sat in decode is already on its way when the branch resolves. That word is marked invalid, so execute sees exactly one bubble. The target word follows in the next cycle. A branch that falls through costs nothing. A downstream stall input freezes the fetch address, the memory read and the decode slot.

The decode slot is a three-state machine (`dslot_e`):

- **DS_BOOT** holds after reset, while the slot has no word yet.
- **DS_LIVE** means the slot holds a correct-path word that is passed on as valid.
- **DS_SHADOW** means the slot holds the wrong-path word fetched behind a taken branch.

The transitions are:

- **boot_fill**: DS_BOOT to DS_LIVE, on the first unstalled edge.
- **flow**: DS_LIVE to DS_LIVE, when no branch is taken.
- **squash**: DS_LIVE to DS_SHADOW, when a branch is taken.
- **recover**: DS_SHADOW to DS_LIVE, on the next unstalled edge.
- **hold**: any state to itself, while stall is high.

Top module: `brfe_frontend`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `imem_addr` is 0, `dec_valid` is 0 and `redirect` is 0.
- R2: On each unstalled cycle without a redirect, `imem_addr` grows by 4. The word read at address A appears on `dec_instr` in the next cycle, with `dec_pc` = A and `dec_valid` = 1.
- R3: A branch-equal is a decode word with bits [31:26] = 6'h04. `rs_idx` shows bits [25:21] and `rt_idx` shows bits [20:16]. `redirect` is 1 when a valid branch-equal is in decode with `rs_val` == `rt_val` and stall low. The branch itself stays valid.
- R4: The target is `dec_pc` + 4 + (sign-extended bits [15:0] shifted left by 2). It is on `imem_addr` in the cycle after `redirect`.
- R5: In the cycle after a taken branch, `dec_valid` is 0. In the cycle after that, `dec_valid` is 1 and `dec_pc` equals the target.
- R6: A branch-equal with unequal operands gives no bubble. The next cycle shows `dec_valid` = 1 with `dec_pc` = branch address + 4.
- R7: A branch-equal in the squashed slot never asserts `redirect`, even with equal operands.
- R8: While `stall` is 1, `imem_en` is 0, `redirect` is 0, and `imem_addr`, `dec_pc` and `dec_valid` hold their values. A branch held in decode redirects once stall falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Downstream freeze request |
| imem_addr | output | PC_W | Fetch byte address |
| imem_en | output | 1 | Memory read enable; the memory output holds when low |
| imem_rdata | input | 32 | Word read at the previous enabled address |
| rs_idx | output | 5 | First source register index of the decode word |
| rt_idx | output | 5 | Second source register index of the decode word |
| rs_val | input | DATA_W | Value of register `rs_idx` |
| rt_val | input | DATA_W | Value of register `rt_idx` |
| dec_valid | output | 1 | Decode word is valid for execute |
| dec_pc | output | PC_W | Address of the decode word |
| dec_instr | output | 32 | Decode word |
| redirect | output | 1 | Taken branch; fetch moves to the target next cycle |

## Verification
The hardest case to reach from the ports is a branch that lands in the squashed slot with matching operands. It can only happen right behind a taken branch, and it must stay silent. The stimulus therefore places a second branch-equal in the word after every branch under test. The bench then sweeps branch positions, forward and backward offsets, and taken and not-taken outcomes. For each run it computes the expected decode address for every cycle. A directed run holds stall while a taken branch waits in decode. This checks that the redirect is deferred rather than lost.

// File: rtl/brfe_pkg.sv
package brfe_pkg;
    typedef enum logic [1:0] {
        DS_BOOT,
        DS_LIVE,
        DS_SHADOW
    } dslot_e;

    localparam logic [5:0] OPC_BEQ = 6'h04;
    localparam int         INSTR_W = 32;
    localparam int         IMM_W   = 16;
    localparam int         REG_IW  = 5;
endpackage

// File: rtl/brfe_fetch.sv
module brfe_fetch #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic            redirect,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;

    always_comb begin
        if (stall)         pc_d = pc_q;
        else if (redirect) pc_d = target;
        else               pc_d = pc_q + STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc = pc_q;

    AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst)
        (!stall && !redirect) |=> pc_q == $past(pc_q) + STEP); // R2
    AST_PC_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        redirect |=> pc_q == $past(target)); // R4
    AST_PC_STALL: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc_q)); // R8
endmodule

// File: rtl/brfe_decode.sv
module brfe_decode
    import brfe_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    input  logic [PC_W-1:0]    fetch_pc,
    input  logic [INSTR_W-1:0] word,
    input  logic [DATA_W-1:0]  rs_val,
    input  logic [DATA_W-1:0]  rt_val,
    output logic               dec_valid,
    output logic [PC_W-1:0]    dec_pc,
    output logic [INSTR_W-1:0] dec_instr,
    output logic [REG_IW-1:0]  rs_idx,
    output logic [REG_IW-1:0]  rt_idx,
    output logic               redirect,
    output logic [PC_W-1:0]    target
);
    localparam int EXT_W = PC_W - IMM_W - 2;

    dslot_e          state_q, state_d;
    logic [PC_W-1:0] dpc_q;
    logic            is_beq;
    logic            taken;
    logic [PC_W-1:0] disp;

    assign is_beq = (word[INSTR_W-1 -: 6] == OPC_BEQ);
    assign disp   = {{EXT_W{word[IMM_W-1]}}, word[IMM_W-1:0], 2'b00};

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_BOOT:   if (!stall) state_d = DS_LIVE;
            DS_LIVE:   if (!stall) state_d = taken ? DS_SHADOW : DS_LIVE;
            DS_SHADOW: if (!stall) state_d = DS_LIVE;
            default:   state_d = DS_BOOT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DS_BOOT;
            dpc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (!stall) dpc_q <= fetch_pc;
        end
    end

    // outputs
    always_comb begin
        dec_valid = 1'b0;
        taken     = 1'b0;
        unique case (state_q)
            DS_BOOT:   dec_valid = 1'b0;
            DS_LIVE: begin
                dec_valid = 1'b1;
                taken     = is_beq && (rs_val == rt_val) && !stall;
            end
            DS_SHADOW: dec_valid = 1'b0;
            default:   dec_valid = 1'b0;
        endcase
    end

    assign redirect  = taken;
    assign target    = dpc_q + PC_W'(4) + disp;
    assign dec_pc    = dpc_q;
    assign dec_instr = word;
    assign rs_idx    = word[25:21];
    assign rt_idx    = word[20:16];

    AST_SQUASH_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !dec_valid); // R5
    AST_SHADOW_QUIET: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !redirect); // R7
    AST_NT_FLOW: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !redirect && !stall) |=> dec_valid); // R6
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(dpc_q) && $stable(dec_valid))); // R8
endmodule

// File: rtl/brfe_frontend.sv
module brfe_frontend
    import brfe_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    output logic [PC_W-1:0]    imem_addr,
    output logic               imem_en,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [REG_IW-1:0]  rs_idx,
    output logic [REG_IW-1:0]  rt_idx,
    input  logic [DATA_W-1:0]  rs_val,
    input  logic [DATA_W-1:0]  rt_val,
    output logic               dec_valid,
    output logic [PC_W-1:0]    dec_pc,
    output logic [INSTR_W-1:0] dec_instr,
    output logic               redirect
);
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] target;

    brfe_fetch #(.PC_W(PC_W)) u_fetch (
        .clk(clk), .rst(rst), .stall(stall),
        .redirect(redirect), .target(target), .pc(pc)
    );

    brfe_decode #(.PC_W(PC_W), .DATA_W(DATA_W)) u_decode (
        .clk(clk), .rst(rst), .stall(stall),
        .fetch_pc(pc), .word(imem_rdata),
        .rs_val(rs_val), .rt_val(rt_val),
        .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_instr(dec_instr),
        .rs_idx(rs_idx), .rt_idx(rt_idx),
        .redirect(redirect), .target(target)
    );

    assign imem_addr = pc;
    assign imem_en   = !stall;

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (imem_addr == '0 && !dec_valid)); // R1
    AST_STALL_NOREAD: assert property (@(posedge clk) disable iff (rst)
        stall |-> !redirect); // R8
endmodule

// File: tb/brfe_frontend_bench.sv
`timescale 1ns/1ps
module brfe_frontend_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [31:0] imem_addr;
    logic        imem_en;
    logic [31:0] imem_rdata = '0;
    logic [4:0]  rs_idx, rt_idx;
    logic [31:0] rs_val = '0, rt_val = '0;
    logic        dec_valid;
    logic [31:0] dec_pc, dec_instr;
    logic        redirect;

    logic [31:0] mem [64];
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) if (imem_en) imem_rdata <= mem[imem_addr[7:2]];

    brfe_frontend u_brfe_frontend (
        .clk(clk), .rst(rst), .stall(stall),
        .imem_addr(imem_addr), .imem_en(imem_en), .imem_rdata(imem_rdata),
        .rs_idx(rs_idx), .rt_idx(rt_idx), .rs_val(rs_val), .rt_val(rt_val),
        .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_instr(dec_instr),
        .redirect(redirect)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] beq(input int off);
        return {6'h04, 5'd3, 5'd7, 16'(off)};
    endfunction

    task automatic load(input int b);
        for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 | (i << 2);
        mem[b/4]   = beq(0);
        mem[b/4+1] = beq(10);
    endtask

    task automatic do_reset();
        rst = 1'b1; stall = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(imem_addr == 0, "R1 addr in reset", imem_addr, 0);
        rst = 1'b0;
        #1;
        chk(imem_addr == 0, "R1 addr", imem_addr, 0);
        chk(dec_valid == 0, "R1 valid", 32'(dec_valid), 0);
        chk(redirect == 0, "R1 redirect", 32'(redirect), 0);
    endtask

    task automatic run_case(input int b, input int off, input bit tk);
        int t, kb;
        logic [31:0] expd;
        bit expv;
        load(b);
        mem[b/4] = beq(off);
        rs_val = 32'd5;
        rt_val = tk ? 32'd5 : 32'd6;
        t  = b + 4 + 4*off;
        kb = b/4 + 1;
        do_reset();
        for (int k = 1; k <= kb + 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            expv = 1'b1;
            if (!tk || k <= kb) expd = 32'(4*(k-1));
            else if (k == kb + 1) begin expv = 1'b0; expd = 0; end
            else expd = 32'(t + 4*(k-kb-2));
            chk(dec_valid == expv, tk ? "R5 valid slot" : "R6 valid slot", 32'(dec_valid), 32'(expv));
            if (expv) begin
                chk(dec_pc == expd, tk && k > kb ? "R5 target pc" : "R2 seq pc", dec_pc, expd);
                chk(dec_instr == mem[expd[7:2]], "R2 word", dec_instr, mem[expd[7:2]]);
            end
            if (k == kb) begin
                chk(rs_idx == 5'd3, "R3 rs_idx", 32'(rs_idx), 3);
                chk(rt_idx == 5'd7, "R3 rt_idx", 32'(rt_idx), 7);
                chk(redirect == tk, "R3 redirect", 32'(redirect), 32'(tk));
            end else begin
                chk(redirect == 0, k == kb + 1 ? "R7 shadow branch quiet" : "R6 no redirect", 32'(redirect), 0);
            end
            if (tk && k == kb + 1)
                chk(imem_addr == 32'(t), "R4 target addr", imem_addr, 32'(t));
        end
    endtask

    task automatic stall_case();
        int b, t;
        logic [31:0] held;
        b = 12; t = 12 + 4 + 12;
        load(b);
        mem[b/4] = beq(3);
        rs_val = 32'd9; rt_val = 32'd9;
        do_reset();
        repeat (4) begin @(posedge clk); @(negedge clk); end
        chk(dec_pc == 32'(b), "R8 at branch", dec_pc, 32'(b));
        stall = 1'b1;
        #1;
        held = imem_addr;
        chk(redirect == 0, "R8 redirect held off", 32'(redirect), 0);
        chk(imem_en == 0, "R8 imem_en", 32'(imem_en), 0);
        repeat (2) begin
            @(posedge clk); @(negedge clk);
            chk(dec_pc == 32'(b), "R8 dec_pc frozen", dec_pc, 32'(b));
            chk(dec_valid == 1, "R8 valid frozen", 32'(dec_valid), 1);
            chk(imem_addr == held, "R8 addr frozen", imem_addr, held);
            chk(dec_instr == mem[b/4], "R8 word frozen", dec_instr, mem[b/4]);
        end
        stall = 1'b0;
        #1;
        chk(redirect == 1, "R8 deferred redirect", 32'(redirect), 1);
        @(posedge clk); @(negedge clk);
        chk(dec_valid == 0, "R5 bubble after stall", 32'(dec_valid), 0);
        chk(imem_addr == 32'(t), "R4 target after stall", imem_addr, 32'(t));
        @(posedge clk); @(negedge clk);
        chk(dec_pc == 32'(t), "R5 target after stall", dec_pc, 32'(t));
    endtask

    initial begin
        for (int b = 20; b <= 40; b += 4) begin
            for (int oi = 0; oi < 8; oi++) begin
                int off;
                off = (oi == 0) ? -5 : (oi == 1) ? -4 : oi - 1;
                run_case(b, off, 1'b1);
                run_case(b, off, 1'b0);
            end
        end
        stall_case();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule